// File: doc/BRIEF.md
# Reciprocal-Based Fixed-Point Divider

This block divides a 16-bit unsigned dividend Y by a 16-bit unsigned divisor X without any subtract-and-shift recurrence. It shifts the divisor left until its top bit is set, picks a starting reciprocal from a small computed table, and sharpens that estimate with Newton-Raphson steps of the form x' = x*(2 - d*x). It then forms the quotient as Y times the reciprocal. Every intermediate rounding is chosen so that the estimate stays at or under the true value. The raw quotient can therefore only fall short, and never by more than one unit.

A separate correction phase computes R = Y - Q*X. It bumps Q by one and subtracts X from R while R is not below X, with two such passes. A per-operation raw flag skips that phase and returns the uncorrected product quotient. One multiplier is shared by all product steps, and only one division is in flight at a time. Operands enter through a valid/ready port. The result leaves through a valid/ready port. Back-pressure rules: in_ready is high only while the block is idle; a result, once presented, stays on the pins unchanged until out_ready is seen high at a clock edge.

Top module: `recip_divider`

## Requirements
- R1: After reset (and after a reset applied during an operation) in_ready is 1, out_valid is 0 and out_err is 0.
- R2: In exact mode (in_raw = 0) with X != 0, out_quo equals floor(Y/X) and out_rem equals Y mod X.
- R3: In raw mode (in_raw = 1) with X != 0, out_quo is never above floor(Y/X) and never below floor(Y/X) - 1.
- R4: In exact mode the reported remainder always satisfies out_rem < X.
- R5: With default parameters, out_valid first rises 9 clock edges after the accepting edge in exact mode, 6 edges after in raw mode, and 1 edge after when X = 0.
- R6: X = 0 sets out_err to 1, returns out_quo = 16'hFFFF and out_rem = Y in either mode; out_err is 0 for any nonzero X.
- R7: in_ready drops on the edge after acceptance and stays low until the result handshake completes; in_valid and operand changes while busy do not alter the result in flight.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_quo, out_rem and out_err hold their values; out_valid falls on the edge where out_ready is 1.
- R9: In raw mode with X != 0, out_rem reads 0 and out_err reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| in_divisor | input | W | Divisor X |
| in_dividend | input | W | Dividend Y |
| in_raw | input | 1 | 1 = skip remainder correction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quo | output | W | Quotient |
| out_rem | output | W | Remainder (0 in raw mode) |
| out_err | output | 1 | Divide-by-zero flag |

## Verification
Each operation is offered at a falling edge and counted from the rising edge that accepts it. The bench then polls out_valid at every following falling edge. The number of rising edges seen before it rises must be exactly 9 in exact mode, 6 in raw mode and 1 for a zero divisor. The result fields are compared at that same falling edge, away from any active edge. For stalled results the bench waits further falling edges before asserting out_ready, and rechecks that the fields are unchanged.

// File: rtl/rd_pkg.sv
package rd_pkg;

  typedef enum logic [3:0] {
    RD_IDLE, RD_NORM, RD_DX, RD_XM, RD_YR, RD_QX, RD_FIX1, RD_FIX2, RD_DONE
  } rd_state_e;

  // Starting reciprocal for bucket idx: 1/(bucket midpoint) with fb fraction bits.
  // The normalized divisor lies in [0.5,1); bucket idx covers
  // [(2^sb + idx)/2^(sb+1), (2^sb + idx + 1)/2^(sb+1)).
  function automatic longint seed_value(input int idx, input int sb, input int fb);
    longint num;
    longint den;
    num = longint'(1) << (sb + 2 + fb);
    den = (longint'(1) << (sb + 1)) + 1 + 2 * longint'(idx);
    return num / den;
  endfunction

endpackage

// File: rtl/rd_normalize.sv
module rd_normalize #(
  parameter int W   = 16,
  parameter int LZW = 4
) (
  input  logic [W-1:0]   value,
  output logic [LZW-1:0] lz,
  output logic [W-1:0]   norm
);
  logic found;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && value[i]) begin
        lz    = LZW'(W - 1 - i);
        found = 1'b1;
      end
    end
    norm = value << lz;
  end
endmodule

// File: rtl/rd_seed.sv
module rd_seed
  import rd_pkg::*;
#(
  parameter int SEED_BITS = 4,
  parameter int FB        = 20,
  parameter int XW        = 22
) (
  input  logic [SEED_BITS-1:0] idx,
  output logic [XW-1:0]        seed
);
  localparam int ENTRIES = 1 << SEED_BITS;

  logic [XW-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    assign tbl[g] = XW'(seed_value(g, SEED_BITS, FB));
  end

  assign seed = tbl[idx];
endmodule

// File: rtl/rd_mult.sv
module rd_mult #(
  parameter int AW = 22
) (
  input  logic [AW-1:0]   a,
  input  logic [AW-1:0]   b,
  output logic [2*AW-1:0] p
);
  assign p = a * b;
endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import rd_pkg::*;
#(
  parameter int W         = 16,
  parameter int SEED_BITS = 4,
  parameter int NR_ITERS  = 2,
  parameter int GUARD     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_divisor,
  input  logic [W-1:0] in_dividend,
  input  logic         in_raw,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quo,
  output logic [W-1:0] out_rem,
  output logic         out_err
);
  localparam int FB  = W + GUARD;          // reciprocal fraction bits
  localparam int XW  = FB + 2;             // reciprocal width, value below 2.0
  localparam int PW  = 2 * XW;             // shared product width
  localparam int LZW = $clog2(W);
  localparam int IW  = $clog2(NR_ITERS + 1);
  localparam int SHB = W + FB;
  localparam logic [PW-1:0] TWO_FX  = PW'(1) << (FB + 1);
  localparam logic [PW-1:0] CEIL_AD = (PW'(1) << W) - PW'(1);

  rd_state_e      st;
  logic [W-1:0]   x_op, y_op, q_r, r_r, d_r;
  logic           raw_r, err_r;
  logic [LZW-1:0] lz_r;
  logic [XW-1:0]  rc_r, m_r;
  logic [IW-1:0]  it_r;

  logic [LZW-1:0] nz_lz;
  logic [W-1:0]   nz_d;
  logic [XW-1:0]  seed_x;
  logic [XW-1:0]  mul_a, mul_b;
  logic [PW-1:0]  prod;
  logic [7:0]     shamt;
  logic [XW-1:0]  m_next, rc_next;
  logic [W-1:0]   q_next, qx_rem;

  rd_normalize #(.W(W), .LZW(LZW)) u_norm (
    .value(x_op), .lz(nz_lz), .norm(nz_d)
  );

  rd_seed #(.SEED_BITS(SEED_BITS), .FB(FB), .XW(XW)) u_seed (
    .idx(nz_d[W-2 -: SEED_BITS]), .seed(seed_x)
  );

  rd_mult #(.AW(XW)) u_mul (.a(mul_a), .b(mul_b), .p(prod));

  // Operand steering for the single multiplier.
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    unique case (st)
      RD_DX:   begin mul_a = XW'(d_r);  mul_b = rc_r;      end
      RD_XM:   begin mul_a = rc_r;      mul_b = m_r;       end
      RD_YR:   begin mul_a = XW'(y_op); mul_b = rc_r;      end
      RD_QX:   begin mul_a = XW'(q_r);  mul_b = XW'(x_op); end
      default: ;
    endcase
  end

  // d*x is rounded up and x*(2-dx) rounded down, so the estimate never overshoots.
  assign m_next  = XW'(TWO_FX - ((prod + CEIL_AD) >> W));
  assign rc_next = XW'(prod >> FB);
  assign shamt   = 8'(SHB) - 8'(lz_r);
  assign q_next  = W'(prod >> shamt);
  assign qx_rem  = y_op - prod[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RD_IDLE;
      x_op  <= '0;
      y_op  <= '0;
      q_r   <= '0;
      r_r   <= '0;
      d_r   <= '0;
      raw_r <= 1'b0;
      err_r <= 1'b0;
      lz_r  <= '0;
      rc_r  <= '0;
      m_r   <= '0;
      it_r  <= '0;
    end else begin
      unique case (st)
        RD_IDLE: if (in_valid) begin
          x_op  <= in_divisor;
          y_op  <= in_dividend;
          raw_r <= in_raw;
          err_r <= 1'b0;
          st    <= RD_NORM;
        end
        RD_NORM: if (x_op == '0) begin
          q_r   <= '1;
          r_r   <= y_op;
          err_r <= 1'b1;
          st    <= RD_DONE;
        end else begin
          lz_r <= nz_lz;
          d_r  <= nz_d;
          rc_r <= seed_x;
          it_r <= '0;
          st   <= RD_DX;
        end
        RD_DX: begin
          m_r <= m_next;
          st  <= RD_XM;
        end
        RD_XM: begin
          rc_r <= rc_next;
          if (it_r == IW'(NR_ITERS - 1)) st <= RD_YR;
          else begin
            it_r <= it_r + 1'b1;
            st   <= RD_DX;
          end
        end
        RD_YR: begin
          q_r <= q_next;
          if (raw_r) begin
            r_r <= '0;
            st  <= RD_DONE;
          end else st <= RD_QX;
        end
        RD_QX: begin
          r_r <= qx_rem;
          st  <= RD_FIX1;
        end
        RD_FIX1, RD_FIX2: begin
          if (r_r >= x_op) begin
            q_r <= q_r + 1'b1;
            r_r <= r_r - x_op;
          end
          st <= (st == RD_FIX1) ? RD_FIX2 : RD_DONE;
        end
        RD_DONE: if (out_ready) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == RD_IDLE);
  assign out_valid = (st == RD_DONE);
  assign out_quo   = q_r;
  assign out_rem   = r_r;
  assign out_err   = err_r;

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quo) && $stable(out_rem) && $stable(out_err)); // R8
  AST_RAW_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    st == RD_QX |-> prod <= PW'(y_op)); // R3
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !raw_r && !out_err |-> out_rem < x_op); // R4
  AST_ZERO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_quo == '1 && out_rem == y_op); // R6
  AST_RAW_REM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && raw_r && !out_err |-> out_rem == '0); // R9
endmodule

// File: tb/sim_recip_divider.sv
`timescale 1ns/1ps
module sim_recip_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_divisor = '0;
  logic [15:0] in_dividend = '0;
  logic        in_raw = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_quo;
  logic [15:0] out_rem;
  logic        out_err;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  recip_divider u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_divisor(in_divisor), .in_dividend(in_dividend), .in_raw(in_raw),
    .out_valid(out_valid), .out_ready(out_ready), .out_quo(out_quo),
    .out_rem(out_rem), .out_err(out_err)
  );

  // {divisor, dividend}
  localparam logic [31:0] VEC [12] = '{
    32'h0007_0064, 32'h0001_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
    32'h0003_FFFF, 32'h8000_FFFF, 32'h00FF_FDE8, 32'h3039_D431,
    32'h0002_0001, 32'h000A_0000, 32'h1001_FFFF, 32'h000D_00A9
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [15:0] x, input logic [15:0] y, input logic raw,
                       input bit junk, input int stall);
    int n;
    int elat;
    logic [15:0] eq, er, hq, hr;
    logic eerr;
    if (x == 0) begin
      eq = 16'hFFFF; er = y; eerr = 1'b1; elat = 1;
    end else begin
      eq = y / x; er = raw ? 16'h0 : y % x; eerr = 1'b0; elat = raw ? 6 : 9;
    end
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready while idle", 32'(in_ready), 1);
    in_divisor = x; in_dividend = y; in_raw = raw; in_valid = 1'b1;
    @(negedge clk);
    if (junk) begin
      in_divisor = ~x; in_dividend = ~y; in_raw = ~raw;
    end else in_valid = 1'b0;
    chk(in_ready == 1'b0, "R7 ready low after accept", 32'(in_ready), 0);
    n = 0;
    while (!out_valid && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 3) in_valid = 1'b0;
    end
    in_valid = 1'b0;
    chk(n == elat, "R5 latency", 32'(n), 32'(elat));
    chk(out_err == eerr, "R6 error flag", 32'(out_err), 32'(eerr));
    if (raw && x != 0) begin
      chk(out_quo <= eq && 17'(out_quo) + 17'd1 >= 17'(eq), "R3 raw quotient", 32'(out_quo), 32'(eq));
      chk(out_rem == 16'h0, "R9 raw remainder", 32'(out_rem), 0);
    end else begin
      chk(out_quo == eq, "R2 quotient", 32'(out_quo), 32'(eq));
      chk(out_rem == er, "R2 remainder", 32'(out_rem), 32'(er));
      if (x != 0) chk(out_rem < x, "R4 remainder below divisor", 32'(out_rem), 32'(x));
    end
    chk(in_ready == 1'b0, "R7 ready low while result pending", 32'(in_ready), 0);
    if (stall > 0) begin
      hq = out_quo; hr = out_rem;
      repeat (stall) @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held", 32'(out_valid), 1);
      chk(out_quo == hq && out_rem == hr, "R8 result stable", {out_quo, out_rem}, {hq, hr});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R8 valid falls on take", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 ready back after take", 32'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no result in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_err == 1'b0, "R1 error clear", 32'(out_err), 0);

    for (int i = 0; i < 12; i++)
      do_op(VEC[i][31:16], VEC[i][15:0], 1'b0, (i % 3) == 1, (i % 4) == 2 ? 3 : 0);
    for (int i = 0; i < 12; i++)
      do_op(VEC[i][31:16], VEC[i][15:0], 1'b1, (i % 3) == 2, (i % 4) == 1 ? 2 : 0);

    // Zero divisor, both modes (R6)
    do_op(16'h0000, 16'h1234, 1'b0, 1'b0, 2);
    do_op(16'h0000, 16'h0000, 1'b1, 1'b0, 0);
    // Error flag cleared by the next good operation (R6)
    do_op(16'h0005, 16'h0011, 1'b0, 1'b0, 0);

    // Reset during an operation returns to idle (R1)
    @(negedge clk);
    in_divisor = 16'h0009; in_dividend = 16'h0050; in_raw = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset mid-operation", {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;
    do_op(16'h0009, 16'h0050, 1'b0, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule